// File: doc/BRIEF.md
# Seven-to-One Multi-Lane Display Serializer

This block turns a wide parallel pixel word into narrow serial streams for a flat-panel link. Each pixel period carries one word. The word is split into seven-bit slices, one slice per data lane, and each lane sends its slice one bit per bit-clock tick. A fixed pattern on a separate clock lane lets the receiver find the word boundaries. The default build has four data lanes and takes a 28-bit word. A three-lane build takes a 21-bit word.

The whole block runs on a bit clock that is supplied from outside. That clock runs at exactly seven times the pixel rate and is phase-aligned to it. An internal slot counter, running from 0 to 6, marks the seven bit slots of each pixel period. One input selects the capture point:

- **Rising mode:** the word is sampled at the start of the period.
- **Falling mode:** the word is sampled at a mid-period slot.

Captured words pass through a holding stage. This lets the next word be taken in while the current word is still shifting out. An active-low power-down input clears all state and disables the outputs at once. After power-down is released, the outputs stay disabled until the first complete word has been captured. The pad drivers use the enable output to tri-state the lines.

Top module: `lvds7_ser`

## Requirements
- R1: While `rst_n` is low, and after it is released until a word has been loaded, `ser_oe`, `ser_dat` and `ser_clk` are all 0. Whenever `ser_oe` is 0, `ser_dat` and `ser_clk` are 0.
- R2: While enabled, lane n drives `pix_word[7n+k]` during slot k of the pixel period, for k = 0 to 6. Bit 0 goes out in slot 0, the first slot of the period.
- R3: While enabled, `ser_clk` follows the pattern 1,1,0,0,0,1,1 over slots 0 to 6. The slot counter wraps from 6 to 0, so the pattern repeats every seven bit-clock cycles.
- R4: With `cap_fall` = 0, the word is sampled at the bit-clock edge that ends slot 0. It is transmitted in slots 0 to 6 of the next period.
- R5: With `cap_fall` = 1, the word is sampled at the edge that ends slot `FALL_SLOT` (default 3). It is transmitted in the next period. A change of `pix_word` after the slot-0 edge is therefore taken in falling mode but not in rising mode.
- R6: Words are double-buffered. While one word shifts out, the next word is captured. Consecutive periods carry consecutive words with no gap, and `ser_oe` stays 1.
- R7: When `pwr_dn_n` goes low, `ser_oe`, `ser_dat` and `ser_clk` become 0 in the same cycle, without waiting for a clock edge.
- R8: On the first edge with `pwr_dn_n` high after a power-down, the slot count is 0. `ser_oe` stays 0 through the first seven edges and becomes 1 after the seventh edge, at slot 0 of the second period.
- R9: With `NUM_LANES` = 3, the word is 21 bits wide and lanes 0 to 2 follow R2 with the same slot timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_bit | input | 1 | Bit clock, seven times the pixel rate and phase-aligned to it |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn_n | input | 1 | Active-low power-down; low clears state and disables outputs |
| cap_fall | input | 1 | Capture point: 0 = start of period, 1 = mid-period slot |
| pix_word | input | 7*NUM_LANES | Parallel pixel word; lane n takes bits [7n+6:7n] |
| ser_dat | output | NUM_LANES | Serial data lanes, bit 0 of each slice first |
| ser_clk | output | 1 | Forwarded clock-lane pattern |
| ser_oe | output | 1 | Output enable for the lane drivers; 0 = high impedance |

## Verification
The assertions assume that the bit clock is already phase-aligned to the pixel period. In other words, slot 0 of the internal count is the start of the period, so slot numbers alone can describe the pattern and the enable timing. They also assume that `pix_word` is stable around the selected capture edge. The stimulus satisfies this by changing the word only at falling bit-clock edges, at points a known number of slots away from both capture slots. A word change after the slot-0 edge and before the mid-period edge makes the two capture modes give different, predictable results.

// File: rtl/lvds7_pkg.sv
// Shared constants for the seven-slot serializer.
// Assumes a fixed frame of seven bit slots per pixel period.
package lvds7_pkg;
    localparam int SLOTS  = 7;
    localparam int SLOT_W = 3;

    typedef logic [SLOT_W-1:0] slot_t;

    localparam slot_t LAST_SLOT = slot_t'(SLOTS - 1);
    localparam slot_t RISE_SLOT = slot_t'(0);

    // Clock-lane level per slot (index = slot). The pattern is symmetric.
    localparam logic [SLOTS-1:0] CLK_LANE_PAT = 7'b1100011;
endpackage

// File: rtl/lvds7_slot_timer.sv
// Slot counter for the pixel period, plus the capture and load strobes.
// Assumes clk is the bit clock and slot 0 starts each pixel period.
// run = 0 (power-down) holds the counter at slot 0.
module lvds7_slot_timer
    import lvds7_pkg::*;
#(
    parameter int FALL_SLOT = 3
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  cap_fall,
    output slot_t slot,
    output logic  cap_stb,
    output logic  load_stb
);
    localparam slot_t FALL_S = slot_t'(FALL_SLOT);

    slot_t slot_q;
    slot_t cap_slot;

    // Step the slot count 0..6; restart at 0 on reset or power-down.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            slot_q <= RISE_SLOT;
        end else if (slot_q == LAST_SLOT) begin
            slot_q <= RISE_SLOT;
        end else begin
            slot_q <= slot_q + slot_t'(1);
        end
    end

    // Choose the capture slot from the edge-select input.
    always_comb begin
        cap_slot = cap_fall ? FALL_S : RISE_SLOT;
    end

    // Strobes that act on the edge ending the current slot.
    always_comb begin
        cap_stb  = run && (slot_q == cap_slot);
        load_stb = run && (slot_q == LAST_SLOT);
    end

    assign slot = slot_q;
endmodule

// File: rtl/lvds7_lane_shifter.sv
// One data lane: a capture register and a shift register behind it.
// Assumes cap_stb and load_stb never fire on the same edge.
// Bit 0 of the slice leaves first.
module lvds7_lane_shifter
    import lvds7_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             cap_stb,
    input  logic             load_stb,
    input  logic [SLOTS-1:0] din,
    output logic             sout
);
    logic [SLOTS-1:0] hold_q;
    logic [SLOTS-1:0] shift_q;

    // Capture stage: take the slice on the capture strobe.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            hold_q <= '0;
        end else if (cap_stb) begin
            hold_q <= din;
        end
    end

    // Shift stage: reload at the period boundary, otherwise move one bit down.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            shift_q <= '0;
        end else if (load_stb) begin
            shift_q <= hold_q;
        end else begin
            shift_q <= shift_q >> 1;
        end
    end

    assign sout = shift_q[0];
endmodule

// File: rtl/lvds7_out_stage.sv
// Output enable tracking, clock-lane pattern and output gating.
// Assumes each capture strobe comes before the next load strobe.
// Power-down gates the outputs combinationally.
module lvds7_out_stage
    import lvds7_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 run,
    input  logic                 cap_stb,
    input  logic                 load_stb,
    input  slot_t                slot,
    input  logic [NUM_LANES-1:0] lane_bit,
    output logic [NUM_LANES-1:0] ser_dat,
    output logic                 ser_clk,
    output logic                 ser_oe
);
    logic word_seen_q;
    logic oe_q;

    // Record that a complete word has been captured since restart.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            word_seen_q <= 1'b0;
        end else if (cap_stb) begin
            word_seen_q <= 1'b1;
        end
    end

    // Turn the outputs on at the first load of a captured word.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            oe_q <= 1'b0;
        end else if (load_stb && word_seen_q) begin
            oe_q <= 1'b1;
        end
    end

    // Gate the data and clock lanes with the enable and power-down.
    always_comb begin
        ser_oe  = oe_q && run;
        ser_dat = ser_oe ? lane_bit : '0;
        ser_clk = ser_oe && CLK_LANE_PAT[slot];
    end
endmodule

// File: rtl/lvds7_ser.sv
// Top of the seven-to-one serializer: slot timer, NUM_LANES lane shifters
// and the output stage. NUM_LANES must be 3 or 4; FALL_SLOT must be 1..5.
module lvds7_ser
    import lvds7_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int FALL_SLOT = 3,
    localparam int WORD_W   = SLOTS * NUM_LANES
) (
    input  logic                 clk_bit,
    input  logic                 rst_n,
    input  logic                 pwr_dn_n,
    input  logic                 cap_fall,
    input  logic [WORD_W-1:0]    pix_word,
    output logic [NUM_LANES-1:0] ser_dat,
    output logic                 ser_clk,
    output logic                 ser_oe
);
    slot_t                slot_w;
    logic                 cap_stb;
    logic                 load_stb;
    logic [NUM_LANES-1:0] lane_bit;

    lvds7_slot_timer #(.FALL_SLOT(FALL_SLOT)) timer_i (
        .clk      (clk_bit),
        .rst_n    (rst_n),
        .run      (pwr_dn_n),
        .cap_fall (cap_fall),
        .slot     (slot_w),
        .cap_stb  (cap_stb),
        .load_stb (load_stb)
    );

    for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
        lvds7_lane_shifter lane_i (
            .clk      (clk_bit),
            .rst_n    (rst_n),
            .run      (pwr_dn_n),
            .cap_stb  (cap_stb),
            .load_stb (load_stb),
            .din      (pix_word[SLOTS*n +: SLOTS]),
            .sout     (lane_bit[n])
        );
    end

    lvds7_out_stage #(.NUM_LANES(NUM_LANES)) out_i (
        .clk      (clk_bit),
        .rst_n    (rst_n),
        .run      (pwr_dn_n),
        .cap_stb  (cap_stb),
        .load_stb (load_stb),
        .slot     (slot_w),
        .lane_bit (lane_bit),
        .ser_dat  (ser_dat),
        .ser_clk  (ser_clk),
        .ser_oe   (ser_oe)
    );
endmodule

// File: rtl/lvds7_ser_chk.sv
// Property checker for lvds7_ser, attached to every instance with bind.
module lvds7_ser_chk
    import lvds7_pkg::*;
#(
    parameter int NUM_LANES = 4
) (
    input logic                 clk_bit,
    input logic                 rst_n,
    input logic                 pwr_dn_n,
    input logic [NUM_LANES-1:0] ser_dat,
    input logic                 ser_clk,
    input logic                 ser_oe,
    input slot_t                slot
);
    AST_IDLE_QUIET: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !ser_oe |-> (ser_dat == '0) && !ser_clk); // R1

    AST_SLOT_RANGE: assert property (@(posedge clk_bit) disable iff (!rst_n)
        slot <= LAST_SLOT); // R3

    AST_SLOT_WRAP: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (slot == LAST_SLOT) |=> (slot == RISE_SLOT)); // R3

    AST_CLK_LOW_MID: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (ser_oe && slot == slot_t'(3)) |-> !ser_clk); // R3

    AST_CLK_HIGH_EDGE: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (ser_oe && slot == RISE_SLOT) |-> ser_clk); // R3

    AST_DOWN_OFF: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !pwr_dn_n |-> !ser_oe && (ser_dat == '0)); // R7

    AST_DOWN_RESTART: assert property (@(posedge clk_bit) disable iff (!rst_n)
        !pwr_dn_n |=> (slot == RISE_SLOT)); // R8

    AST_OE_AT_START: assert property (@(posedge clk_bit) disable iff (!rst_n)
        $rose(ser_oe) |-> (slot == RISE_SLOT)); // R8

    AST_OE_HOLDS: assert property (@(posedge clk_bit) disable iff (!rst_n)
        (ser_oe && pwr_dn_n) |=> (ser_oe || !pwr_dn_n || !rst_n)); // R6
endmodule

bind lvds7_ser lvds7_ser_chk #(.NUM_LANES(NUM_LANES)) chk_i (
    .clk_bit  (clk_bit),
    .rst_n    (rst_n),
    .pwr_dn_n (pwr_dn_n),
    .ser_dat  (ser_dat),
    .ser_clk  (ser_clk),
    .ser_oe   (ser_oe),
    .slot     (slot_w)
);

// File: tb/lvds7_ser_tb_top.sv
// Bench: a vector table walked by one loop, then directed reset and
// power-down cases. Drives inputs and samples outputs at falling edges.
module lvds7_ser_tb_top;
    localparam logic [6:0] PAT = 7'b1100011;
    // {cap_fall, first word, early word, late word}
    localparam logic [84:0] VEC [4] = '{
        {1'b0, 28'hA5A5A5A, 28'h0000001, 28'hFFFFFFF},
        {1'b1, 28'h1234567, 28'h7654321, 28'h0F0F0F0},
        {1'b0, 28'hFFFFFFF, 28'h0000000, 28'h8000000},
        {1'b1, 28'h0000000, 28'hC3C3C3C, 28'h3C3C3C3}
    };

    logic        clk_bit = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn_n = 1'b0;
    logic        cap_fall = 1'b0;
    logic [27:0] pix_word = '0;
    logic [3:0]  ser_dat;
    logic        ser_clk, ser_oe;
    logic [2:0]  ser_dat3;
    logic        ser_clk3, ser_oe3;
    int          checks = 0;
    int          fails = 0;
    bit          done = 1'b0;

    always #4 clk_bit = ~clk_bit;

    lvds7_ser dut_i (
        .clk_bit(clk_bit), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n),
        .cap_fall(cap_fall), .pix_word(pix_word),
        .ser_dat(ser_dat), .ser_clk(ser_clk), .ser_oe(ser_oe)
    );

    lvds7_ser #(.NUM_LANES(3)) dut3_i (
        .clk_bit(clk_bit), .rst_n(rst_n), .pwr_dn_n(pwr_dn_n),
        .cap_fall(cap_fall), .pix_word(pix_word[20:0]),
        .ser_dat(ser_dat3), .ser_clk(ser_clk3), .ser_oe(ser_oe3)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk_bit);
        @(negedge clk_bit);
    endtask

    function automatic logic [3:0] slice_bits(input logic [27:0] w, input int k);
        logic [3:0] r;
        for (int n = 0; n < 4; n++) r[n] = w[7*n + k];
        return r;
    endfunction

    // One period of expected output from word w, with its own tag.
    task automatic check_period(input logic [27:0] w, input string tag);
        for (int k = 0; k < 7; k++) begin
            check({tag, " R2 data"}, 32'(ser_dat), 32'(slice_bits(w, k)));
            check("R3 clock lane", 32'(ser_clk), 32'(PAT[k]));
            check("R9 three-lane data", 32'(ser_dat3), 32'(slice_bits(w, k) & 4'h7));
            check("R6 enable held", 32'(ser_oe), 32'd1);
            step();
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk_bit);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        // R1: outputs quiet during reset
        step();
        step();
        check("R1 oe in reset", 32'(ser_oe), 32'd0);
        check("R1 data in reset", 32'(ser_dat), 32'd0);
        check("R1 clk in reset", 32'(ser_clk), 32'd0);
        rst_n = 1'b1;
        pwr_dn_n = 1'b1;
        pix_word = 28'h5555555;
        step();
        check("R1 oe before load", 32'(ser_oe), 32'd0);
        step();

        foreach (VEC[i]) begin
            logic [27:0] wa, wb, wc;
            cap_fall = VEC[i][84];
            wa = VEC[i][83:56];
            wb = VEC[i][55:28];
            wc = VEC[i][27:0];
            // R7: power-down disables outputs without a clock edge
            pwr_dn_n = 1'b0;
            #1;
            check("R7 oe drop", 32'(ser_oe), 32'd0);
            check("R7 data drop", 32'(ser_dat), 32'd0);
            @(negedge clk_bit);
            step();
            check("R7 oe in power-down", 32'(ser_oe), 32'd0);
            // R8: restart, first word held over the whole first period
            pix_word = wa;
            pwr_dn_n = 1'b1;
            for (int k = 0; k < 7; k++) begin
                step();
                if (k < 6) begin
                    check("R8 oe still off", 32'(ser_oe), 32'd0);
                    check("R1 data off", 32'(ser_dat), 32'd0);
                end else begin
                    check("R8 oe on after seven edges", 32'(ser_oe), 32'd1);
                    check("R9 three-lane oe", 32'(ser_oe3), 32'd1);
                end
            end
            // Second period: first word out; early and late words offered
            for (int k = 0; k < 7; k++) begin
                check("R2 first word", 32'(ser_dat), 32'(slice_bits(wa, k)));
                check("R3 clock lane", 32'(ser_clk), 32'(PAT[k]));
                check("R9 three-lane clock", 32'(ser_clk3), 32'(PAT[k]));
                if (k == 0) pix_word = wb;
                if (k == 1) pix_word = wc;
                step();
            end
            // Third period: rising mode sends the early word, falling the late one
            if (cap_fall) check_period(wc, "R5 falling capture");
            else          check_period(wb, "R4 rising capture");
            // R6: late word is still on the input, so it streams next
            check_period(wc, "R6 back-to-back");
        end

        // R1: reset in the middle of a stream
        rst_n = 1'b0;
        step();
        check("R1 oe after mid reset", 32'(ser_oe), 32'd0);
        check("R1 clk after mid reset", 32'(ser_clk), 32'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule